// File: doc/BRIEF.md
# I2C Status Flag Controller

This block holds the four event flags that an I2C peripheral reports to software: receive data ready, stop seen as a slave, 10-bit header sent as a master, and byte transfer finished. It sits beside the bit-level shift engine. Each cycle it takes single-cycle event pulses from that engine, together with the mode bits and the register access strobes, and updates one registered flag per event.

Each flag has its own set condition and its own suppression cases. Some flags clear on a single data-register access. The stop and header flags clear only after two steps: software reads the status register while the flag is up, and then writes the register that belongs to that flag. When a set and a clear land in the same cycle, the set takes effect. Dropping the peripheral enable forces every flag and every pending clear sequence back to zero.

Top module: `i2c_evt_flags`

## Requirements
- R1: All four flags are 0 after reset. One cycle after `en` is low, all flags are 0, even if set events arrive in that cycle.
- R2: `rx_full` sets one cycle after `ev_byte_rx` while `is_tx`=0. It does not set when `ev_addr_phase` or `ev_arb_lost` is high in the same cycle.
- R3: `rx_full` clears after `wr_data`, and after `rd_data` while `xfer_done`=0. After `rd_data` while `xfer_done`=1, it stays at 1.
- R4: `stop_det` sets after `ev_stop_seen` when `is_master`=0, `ack_en`=1 and `ev_nack`=0. Otherwise it stays unchanged.
- R5: `stop_det` clears only after `wr_ctrl` in a cycle later than an `rd_stat` that saw `stop_det`=1. A lone `wr_ctrl`, or one in the same cycle as the read, has no effect.
- R6: `hdr10` sets after `ev_hdr_sent` when `is_master`=1 and `ev_nack`=0. It clears only after `wr_data` that follows an armed `rd_stat`. A `wr_ctrl` does not clear it.
- R7: `xfer_done` sets only while `no_stretch`=0 and `ev_nack`=0. In receive it sets on an accepted `ev_byte_rx` while `rx_full` is already 1. In transmit it sets on `ev_slot_due` while `tx_empty`=1.
- R8: In transmit with `pec_en`=1 and `pec_next`=1, `ev_slot_due` does not set `xfer_done`.
- R9: `xfer_done` clears after `rd_data`, after `wr_data`, or after `ev_start_stop` while `is_tx`=1.
- R10: A set event beats a clear event in the same cycle. A set event on a flag that is already up cancels its armed status read, so the next matching write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Peripheral enable |
| no_stretch | input | 1 | Clock stretching disabled |
| is_tx | input | 1 | Transmitter mode |
| is_master | input | 1 | Master mode (0 = slave) |
| ack_en | input | 1 | Acknowledge enabled |
| pec_en | input | 1 | Packet error checking enabled |
| pec_next | input | 1 | Next byte to send is the PEC byte |
| tx_empty | input | 1 | Transmit data register empty |
| ev_byte_rx | input | 1 | Data byte received, ACK pulse done |
| ev_addr_phase | input | 1 | Current byte belongs to the address phase |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_nack | input | 1 | NACK on the current byte |
| ev_stop_seen | input | 1 | Stop condition detected on the bus |
| ev_hdr_sent | input | 1 | First byte of a 10-bit address sent |
| ev_slot_due | input | 1 | Next transmit byte is due |
| ev_start_stop | input | 1 | Start or stop condition generated |
| rd_stat | input | 1 | Status register read strobe |
| wr_ctrl | input | 1 | Control register write strobe |
| rd_data | input | 1 | Data register read strobe |
| wr_data | input | 1 | Data register write strobe |
| rx_full | output | 1 | Receive data ready flag |
| stop_det | output | 1 | Stop detected flag |
| hdr10 | output | 1 | 10-bit header sent flag |
| xfer_done | output | 1 | Byte transfer finished flag |

## Verification
Some behaviour is checked by properties on every cycle:
- the disable clearing all flags;
- the gating of the receive flag by the address phase and by lost arbitration;
- NACK, stretching and PEC suppressing their flags;
- a stop or header flag falling only after its matching write;
- a set beating a same-cycle data read.

The two-step clear sequences need the bench's scenarios, which a single-cycle property cannot show. These cover:
- the read and write arriving in the same cycle;
- a write to the wrong register;
- a re-set that cancels an armed read;
- the receive flag staying up when data is read while the transfer-finished flag is set.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
   localparam int NFLAG  = 4;
   localparam int F_RXF  = 0;
   localparam int F_STOP = 1;
   localparam int F_HDR  = 2;
   localparam int F_BTF  = 3;

   typedef logic [NFLAG-1:0] flag_vec_t;

   // flags that need a status read before their clearing write
   function automatic bit needs_arm(input int idx);
      return (idx == F_STOP) || (idx == F_HDR);
   endfunction
endpackage

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell #(
   parameter bit TWO_STEP = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kill_i,
   input  logic set_i,
   input  logic clr_i,
   input  logic arm_i,
   output logic flag_o
);
   logic flag_q;
   logic do_clr;

   generate
      if (TWO_STEP) begin : g_seq
         logic armed_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         armed_q <= 1'b0;
            else if (kill_i || set_i || !flag_q) armed_q <= 1'b0;
            else if (clr_i && armed_q)          armed_q <= 1'b0;
            else if (arm_i)                     armed_q <= 1'b1;
         end
         assign do_clr = clr_i && armed_q;
      end else begin : g_direct
         assign do_clr = clr_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (kill_i) flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (do_clr) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/i2c_flag_events.sv
module i2c_flag_events
   import i2c_flag_pkg::*;
(
   input  logic      en,
   input  logic      no_stretch,
   input  logic      is_tx,
   input  logic      is_master,
   input  logic      ack_en,
   input  logic      pec_en,
   input  logic      pec_next,
   input  logic      tx_empty,
   input  logic      ev_byte_rx,
   input  logic      ev_addr_phase,
   input  logic      ev_arb_lost,
   input  logic      ev_nack,
   input  logic      ev_stop_seen,
   input  logic      ev_hdr_sent,
   input  logic      ev_slot_due,
   input  logic      ev_start_stop,
   input  logic      rd_stat,
   input  logic      wr_ctrl,
   input  logic      rd_data,
   input  logic      wr_data,
   input  flag_vec_t flags_q,
   output flag_vec_t set_v,
   output flag_vec_t clr_v,
   output flag_vec_t arm_v,
   output logic      kill
);
   logic rx_take, btf_rx, btf_tx;

   always_comb begin
      rx_take = en && !is_tx && ev_byte_rx && !ev_addr_phase && !ev_arb_lost;
      btf_rx  = rx_take && flags_q[F_RXF];
      btf_tx  = is_tx && ev_slot_due && tx_empty && !(pec_en && pec_next);

      set_v         = '0;
      set_v[F_RXF]  = rx_take;
      set_v[F_STOP] = ev_stop_seen && !is_master && ack_en && !ev_nack;
      set_v[F_HDR]  = ev_hdr_sent && is_master && !ev_nack;
      set_v[F_BTF]  = !no_stretch && !ev_nack && (btf_rx || btf_tx);

      clr_v         = '0;
      clr_v[F_RXF]  = wr_data || (rd_data && !flags_q[F_BTF]);
      clr_v[F_STOP] = wr_ctrl;
      clr_v[F_HDR]  = wr_data;
      clr_v[F_BTF]  = rd_data || wr_data || (is_tx && ev_start_stop);

      arm_v = {NFLAG{rd_stat}};
      kill  = !en;
   end
endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags
   import i2c_flag_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic no_stretch,
   input  logic is_tx,
   input  logic is_master,
   input  logic ack_en,
   input  logic pec_en,
   input  logic pec_next,
   input  logic tx_empty,
   input  logic ev_byte_rx,
   input  logic ev_addr_phase,
   input  logic ev_arb_lost,
   input  logic ev_nack,
   input  logic ev_stop_seen,
   input  logic ev_hdr_sent,
   input  logic ev_slot_due,
   input  logic ev_start_stop,
   input  logic rd_stat,
   input  logic wr_ctrl,
   input  logic rd_data,
   input  logic wr_data,
   output logic rx_full,
   output logic stop_det,
   output logic hdr10,
   output logic xfer_done
);
   flag_vec_t flags_q, set_v, clr_v, arm_v;
   logic      kill;

   if (NFLAG != 4) begin : g_bad_cfg
      $error("i2c_evt_flags expects exactly four flags");
   end

   i2c_flag_events u_evt (
      .en(en), .no_stretch(no_stretch), .is_tx(is_tx), .is_master(is_master),
      .ack_en(ack_en), .pec_en(pec_en), .pec_next(pec_next), .tx_empty(tx_empty),
      .ev_byte_rx(ev_byte_rx), .ev_addr_phase(ev_addr_phase),
      .ev_arb_lost(ev_arb_lost), .ev_nack(ev_nack), .ev_stop_seen(ev_stop_seen),
      .ev_hdr_sent(ev_hdr_sent), .ev_slot_due(ev_slot_due),
      .ev_start_stop(ev_start_stop), .rd_stat(rd_stat), .wr_ctrl(wr_ctrl),
      .rd_data(rd_data), .wr_data(wr_data), .flags_q(flags_q),
      .set_v(set_v), .clr_v(clr_v), .arm_v(arm_v), .kill(kill)
   );

   for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
      i2c_flag_cell #(.TWO_STEP(needs_arm(gi))) u_cell (
         .clk(clk), .rst_n(rst_n), .kill_i(kill),
         .set_i(set_v[gi]), .clr_i(clr_v[gi]), .arm_i(arm_v[gi]),
         .flag_o(flags_q[gi])
      );
   end

   assign rx_full   = flags_q[F_RXF];
   assign stop_det  = flags_q[F_STOP];
   assign hdr10     = flags_q[F_HDR];
   assign xfer_done = flags_q[F_BTF];
endmodule

// File: rtl/i2c_flag_chk.sv
module i2c_flag_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic no_stretch,
   input logic is_tx,
   input logic pec_en,
   input logic pec_next,
   input logic ev_byte_rx,
   input logic ev_addr_phase,
   input logic ev_arb_lost,
   input logic ev_nack,
   input logic rd_data,
   input logic wr_ctrl,
   input logic wr_data,
   input logic rx_full,
   input logic stop_det,
   input logic hdr10,
   input logic xfer_done
);
   // R1
   off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !(rx_full || stop_det || hdr10 || xfer_done));
   // R2
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_full && (ev_addr_phase || ev_arb_lost || is_tx)) |=> !rx_full);
   // R4
   nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_nack && !stop_det) |=> !stop_det);
   // R5
   stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_det) |-> ($past(wr_ctrl) || !$past(en)));
   // R6
   hdr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hdr10) |-> ($past(wr_data) || !$past(en)));
   // R7
   stretch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (no_stretch && !xfer_done) |=> !xfer_done);
   // R7
   nack_btf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_nack && !xfer_done) |=> !xfer_done);
   // R8
   pec_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_tx && pec_en && pec_next && !xfer_done) |=> !xfer_done);
   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !is_tx && ev_byte_rx && !ev_addr_phase && !ev_arb_lost && rd_data)
      |=> rx_full);
endmodule

bind i2c_evt_flags i2c_flag_chk u_chk (.*);

// File: tb/i2c_evt_flags_tb.sv
module i2c_evt_flags_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b1, no_stretch = 1'b0, is_tx = 1'b0, is_master = 1'b0;
   logic ack_en = 1'b1, pec_en = 1'b0, pec_next = 1'b0, tx_empty = 1'b1;
   logic ev_byte_rx = 1'b0, ev_addr_phase = 1'b0, ev_arb_lost = 1'b0, ev_nack = 1'b0;
   logic ev_stop_seen = 1'b0, ev_hdr_sent = 1'b0, ev_slot_due = 1'b0, ev_start_stop = 1'b0;
   logic rd_stat = 1'b0, wr_ctrl = 1'b0, rd_data = 1'b0, wr_data = 1'b0;
   logic rx_full, stop_det, hdr10, xfer_done;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_evt_flags u_dut (.*);

   // flag vector {xfer_done, hdr10, stop_det, rx_full}
   function automatic logic [3:0] got();
      return {xfer_done, hdr10, stop_det, rx_full};
   endfunction

   task automatic compare(input logic [3:0] e, input string t);
      n_chk++;
      if (got() !== e) begin
         n_bad++;
         $display("FAIL %s: flags actual %b expected %b", t, got(), e);
      end
   endtask

   // monitor: compares just after each edge
   always begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
   end

   // driver: push expectation for this edge, then step to next negedge
   task automatic cyc(input logic [3:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      {ev_byte_rx, ev_addr_phase, ev_arb_lost, ev_nack, ev_stop_seen,
       ev_hdr_sent, ev_slot_due, ev_start_stop} = '0;
      {rd_stat, wr_ctrl, rd_data, wr_data} = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare(4'b0000, "R1 reset");
      rst_n = 1'b1;
      // receive flag and gating
      ev_byte_rx = 1; ev_addr_phase = 1; cyc(4'b0000, "R2 addr phase");
      ev_byte_rx = 1; ev_arb_lost = 1;   cyc(4'b0000, "R2 arb lost");
      ev_byte_rx = 1;                    cyc(4'b0001, "R2 byte");
      ev_byte_rx = 1;                    cyc(4'b1001, "R7 rx btf");
      rd_data = 1;                       cyc(4'b0001, "R3 read while btf");
      rd_data = 1;                       cyc(4'b0000, "R3 read");
      no_stretch = 1;
      ev_byte_rx = 1;                    cyc(4'b0001, "R7 no stretch a");
      ev_byte_rx = 1;                    cyc(4'b0001, "R7 no stretch b");
      wr_data = 1;                       cyc(4'b0000, "R3 write");
      no_stretch = 0;
      ev_byte_rx = 1;                    cyc(4'b0001, "R2 byte");
      ev_byte_rx = 1; ev_nack = 1;       cyc(4'b0001, "R7 nack rx");
      rd_data = 1;                       cyc(4'b0000, "R3 read");
      ev_byte_rx = 1; rd_data = 1;       cyc(4'b0001, "R10 set beats read");
      rd_data = 1;                       cyc(4'b0000, "R3 read");
      // stop flag
      ev_stop_seen = 1; ev_nack = 1;     cyc(4'b0000, "R4 nack");
      ack_en = 0;
      ev_stop_seen = 1;                  cyc(4'b0000, "R4 ack off");
      ack_en = 1;
      ev_stop_seen = 1;                  cyc(4'b0010, "R4 set");
      wr_ctrl = 1;                       cyc(4'b0010, "R5 lone write");
      rd_stat = 1;                       cyc(4'b0010, "R5 read");
      wr_ctrl = 1;                       cyc(4'b0000, "R5 clear");
      ev_stop_seen = 1;                  cyc(4'b0010, "R4 set");
      rd_stat = 1; wr_ctrl = 1;          cyc(4'b0010, "R5 same cycle");
      wr_ctrl = 1;                       cyc(4'b0000, "R5 clear after");
      ev_stop_seen = 1;                  cyc(4'b0010, "R4 set");
      rd_stat = 1;                       cyc(4'b0010, "R10 arm");
      ev_stop_seen = 1;                  cyc(4'b0010, "R10 reset");
      wr_ctrl = 1;                       cyc(4'b0010, "R10 disarmed");
      rd_stat = 1;                       cyc(4'b0010, "R5 read");
      wr_ctrl = 1;                       cyc(4'b0000, "R5 clear");
      // header flag
      is_master = 1;
      ev_hdr_sent = 1; ev_nack = 1;      cyc(4'b0000, "R6 nack");
      ev_hdr_sent = 1;                   cyc(4'b0100, "R6 set");
      wr_data = 1;                       cyc(4'b0100, "R6 lone write");
      rd_stat = 1;                       cyc(4'b0100, "R6 read");
      wr_ctrl = 1;                       cyc(4'b0100, "R6 wrong write");
      wr_data = 1;                       cyc(4'b0000, "R6 clear");
      // transmit path
      is_tx = 1;
      ev_slot_due = 1;                   cyc(4'b1000, "R7 tx set");
      wr_data = 1;                       cyc(4'b0000, "R9 write");
      tx_empty = 0;
      ev_slot_due = 1;                   cyc(4'b0000, "R7 tx full");
      tx_empty = 1;
      ev_slot_due = 1;                   cyc(4'b1000, "R7 tx set");
      ev_start_stop = 1;                 cyc(4'b0000, "R9 start stop");
      pec_en = 1; pec_next = 1;
      ev_slot_due = 1;                   cyc(4'b0000, "R8 pec next");
      pec_next = 0;
      ev_slot_due = 1;                   cyc(4'b1000, "R8 pec not next");
      rd_data = 1;                       cyc(4'b0000, "R9 read");
      no_stretch = 1;
      ev_slot_due = 1;                   cyc(4'b0000, "R7 tx no stretch");
      no_stretch = 0; pec_en = 0; is_tx = 0; is_master = 0;
      // disable
      ev_stop_seen = 1;                  cyc(4'b0010, "R4 set");
      ev_byte_rx = 1;                    cyc(4'b0011, "R2 byte");
      en = 0; ev_byte_rx = 1; ev_stop_seen = 1; cyc(4'b0000, "R1 disable");
      en = 1;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule